// File: doc/BRIEF.md
# ECC First-Error Capture Register

This block sits beside a memory controller's SECDED checker and keeps a record of the first ECC event that checker reports. Each cycle the checker may pulse a single-bit-error strobe or a multi-bit-error strobe. With either strobe it supplies the failing 32-bit physical address and the 8-bit syndrome. The block stores the kind of error, the upper 19 address bits and the syndrome, then ignores every later event until software clears the record.

Software sees one 32-bit register. It is read combinationally and written with byte enables. The register holds two write-one-to-clear status flags, two interrupt enables and one bit that turns scrubbing off. The block drives three outputs:
- a level non-maskable-interrupt request for logged single-bit errors;
- a level system-error request for logged multi-bit errors;
- a scrub-enable signal that tells the write-back engine whether a corrected read may be written back to memory.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset the register reads 0x00000000, `nmi_req` and `serr_req` are 0, and `scrub_en` is 1.
- R2: While the register holds no error, a single-bit strobe sets bit 0 on the next clock edge. On the same edge it loads `err_addr[31:13]` into bits 30:12 and `err_syndrome` into bits 11:4.
- R3: While the register holds no error, a multi-bit strobe sets bit 1 on the next clock edge. It loads the address and syndrome fields in the same way as R2.
- R4: If both strobes arrive together while the register holds no error, only bit 1 (multi-bit) is set. Bit 0 stays 0.
- R5: While bit 0 or bit 1 is set, further strobes change neither flag and leave bits 30:4 unchanged.
- R6: A write with `reg_be[0]` high and `reg_wdata[0]` or `reg_wdata[1]` equal to 1 clears both flags. Writing 0 to both of those bits leaves the flags unchanged. A write with `reg_be[0]` low also leaves them unchanged.
- R7: A strobe that arrives in the same cycle as a clearing write is captured. The register ends that cycle holding the new error.
- R8: Clearing the flags leaves bits 30:4 at their captured values until the next capture.
- R9: A write with `reg_be[0]` high loads bits 3:2 from `reg_wdata[3:2]`. A write with `reg_be[3]` high loads bit 31. Writes through `reg_be[1]` or `reg_be[2]` change no bit.
- R10: `nmi_req` equals bit 0 AND bit 2. `serr_req` equals bit 1 AND bit 3. Both are levels.
- R11: `scrub_en` is the inverse of bit 31. A value of 1 means a corrected read may be written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sbe_strobe | input | 1 | Single-bit (corrected) error reported this cycle |
| mbe_strobe | input | 1 | Multi-bit (uncorrectable) error reported this cycle |
| err_addr | input | 32 | Physical address of the read that failed |
| err_syndrome | input | 8 | Syndrome of the read that failed |
| reg_wr_en | input | 1 | Register write this cycle |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register contents |
| nmi_req | output | 1 | Non-maskable-interrupt request (level) |
| serr_req | output | 1 | System-error request (level) |
| scrub_en | output | 1 | Scrub write-back of corrected reads allowed |

## Verification
The assertions assume four things about the inputs:
- The strobes and the write port are sampled only on rising edges.
- The inputs are never unknown outside reset.
- A clearing write is fully described by `reg_wr_en`, `reg_be[0]` and `reg_wdata[1:0]`.
- Address and syndrome are meaningful only in a cycle with a strobe.

The stimulus drives every input on the falling edge and holds it steady through the next rising edge. The random phase draws the strobes, including both at once, together with arbitrary byte-enable writes. This exercises captures under every combination of held state, clearing write and new error.

// File: rtl/ecc_cap_pkg.sv
// Package: field positions of the capture register and the error-kind type.
// Assumes a 32-bit register. The flags sit in byte 0 so that one byte enable
// reaches the flags and the two interrupt enables together.
package ecc_cap_pkg;
    localparam int REG_W         = 32;
    localparam int BIT_SBE       = 0;
    localparam int BIT_MBE       = 1;
    localparam int BIT_NMI_EN    = 2;
    localparam int BIT_SERR_EN   = 3;
    localparam int SYN_LSB       = 4;
    localparam int SYN_FLD_W     = 8;
    localparam int ADDR_LSB      = 12;
    localparam int ADDR_FLD_W    = 19;
    localparam int BIT_SCRUB_DIS = 31;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'b00,
        ERR_SINGLE = 2'b01,
        ERR_MULTI  = 2'b10
    } err_kind_e;
endpackage

// File: rtl/ecc_ctl_bits.sv
// Control bits of the capture register: the two interrupt enables and the
// scrub-disable bit. Each is written only when its byte lane is enabled.
// Assumes a synchronous active-low reset, which sets every bit to 0.
module ecc_ctl_bits
    import ecc_cap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W/8-1:0]   be,
    input  logic [REG_W-1:0]     wdata,
    output logic                 nmi_en,
    output logic                 serr_en,
    output logic                 scrub_dis
);
    localparam int NMI_LANE   = BIT_NMI_EN / 8;
    localparam int SERR_LANE  = BIT_SERR_EN / 8;
    localparam int SCRUB_LANE = BIT_SCRUB_DIS / 8;

    // Load each control bit from the write data when its lane is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_en    <= 1'b0;
            serr_en   <= 1'b0;
            scrub_dis <= 1'b0;
        end else if (wr_en) begin
            if (be[NMI_LANE])   nmi_en    <= wdata[BIT_NMI_EN];
            if (be[SERR_LANE])  serr_en   <= wdata[BIT_SERR_EN];
            if (be[SCRUB_LANE]) scrub_dis <= wdata[BIT_SCRUB_DIS];
        end
    end
endmodule

// File: rtl/ecc_first_err_latch.sv
// Holds the first reported ECC error: its kind, its address field and its
// syndrome. A multi-bit error wins over a single-bit error in the same cycle.
// A clear empties the record. A strobe in the clearing cycle is still taken.
// Address and syndrome change only on a capture.
module ecc_first_err_latch
    import ecc_cap_pkg::*;
#(
    parameter int FLD_W = 19,
    parameter int SYN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sbe_in,
    input  logic             mbe_in,
    input  logic [FLD_W-1:0] addr_fld,
    input  logic [SYN_W-1:0] syn_in,
    input  logic             clr,
    output err_kind_e        kind_q,
    output logic [FLD_W-1:0] addr_q,
    output logic [SYN_W-1:0] syn_q
);
    logic keep;
    logic take;

    // The record stays locked while it is held and no clear arrives.
    always_comb begin
        keep = (kind_q != ERR_NONE) && !clr;
        take = !keep && (sbe_in || mbe_in);
    end

    // Capture a new error, or empty the record on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= ERR_NONE;
            addr_q <= '0;
            syn_q  <= '0;
        end else if (take) begin
            kind_q <= mbe_in ? ERR_MULTI : ERR_SINGLE;
            addr_q <= addr_fld;
            syn_q  <= syn_in;
        end else if (clr) begin
            kind_q <= ERR_NONE;
        end
    end
endmodule

// File: rtl/ecc_err_capture.sv
// Top of the ECC first-error capture register. It decodes the
// write-one-to-clear of the status flags, assembles the readback word and
// drives the interrupt, system-error and scrub-enable outputs as levels.
// Assumes that the checker's strobes are single-cycle and synchronous to clk.
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SYN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sbe_strobe,
    input  logic              mbe_strobe,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [SYN_W-1:0]  err_syndrome,
    input  logic              reg_wr_en,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              nmi_req,
    output logic              serr_req,
    output logic              scrub_en
);
    localparam int FLAG_LANE = BIT_SBE / 8;

    logic                  clr_flags;
    logic                  nmi_en, serr_en, scrub_dis;
    err_kind_e             kind;
    logic [ADDR_FLD_W-1:0] addr_q;
    logic [SYN_W-1:0]      syn_q;

    // A clear is any write through the flag lane with a 1 in either flag bit.
    always_comb begin
        clr_flags = reg_wr_en && reg_be[FLAG_LANE]
                    && (reg_wdata[BIT_SBE] || reg_wdata[BIT_MBE]);
    end

    ecc_ctl_bits u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .be        (reg_be),
        .wdata     (reg_wdata),
        .nmi_en    (nmi_en),
        .serr_en   (serr_en),
        .scrub_dis (scrub_dis)
    );

    ecc_first_err_latch #(
        .FLD_W (ADDR_FLD_W),
        .SYN_W (SYN_W)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .sbe_in   (sbe_strobe),
        .mbe_in   (mbe_strobe),
        .addr_fld (err_addr[ADDR_W-1 -: ADDR_FLD_W]),
        .syn_in   (err_syndrome),
        .clr      (clr_flags),
        .kind_q   (kind),
        .addr_q   (addr_q),
        .syn_q    (syn_q)
    );

    // Assemble the readback word from the stored fields.
    always_comb begin
        reg_rdata                                = '0;
        reg_rdata[BIT_SBE]                       = (kind == ERR_SINGLE);
        reg_rdata[BIT_MBE]                       = (kind == ERR_MULTI);
        reg_rdata[BIT_NMI_EN]                    = nmi_en;
        reg_rdata[BIT_SERR_EN]                   = serr_en;
        reg_rdata[SYN_LSB +: SYN_FLD_W]          = syn_q;
        reg_rdata[ADDR_LSB +: ADDR_FLD_W]        = addr_q;
        reg_rdata[BIT_SCRUB_DIS]                 = scrub_dis;
    end

    // Level outputs: each request is its flag gated by its enable.
    always_comb begin
        nmi_req  = (kind == ERR_SINGLE) && nmi_en;
        serr_req = (kind == ERR_MULTI)  && serr_en;
        scrub_en = !scrub_dis;
    end
endmodule

// File: rtl/ecc_err_capture_chk.sv
// Checker for the capture register, written on its ports only. Assumes the
// default field layout: flags in bits 1:0, enables in bits 3:2, syndrome and
// address in bits 30:4, scrub-disable in bit 31.
module ecc_err_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sbe_strobe,
    input logic        mbe_strobe,
    input logic        reg_wr_en,
    input logic [3:0]  reg_be,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        nmi_req,
    input logic        serr_req,
    input logic        scrub_en
);
    logic wr_clear;
    logic any_strobe;

    // Decode a clearing write and a strobe from the bus, independently of the RTL.
    always_comb begin
        wr_clear   = reg_wr_en && reg_be[0] && (reg_wdata[1:0] != 2'b00);
        any_strobe = sbe_strobe || mbe_strobe;
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rdata[0] && reg_rdata[1])); // R4

    AST_MBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1:0] == 2'b00 && sbe_strobe && mbe_strobe)
        |=> (reg_rdata[1:0] == 2'b10)); // R4

    AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1:0] != 2'b00 && !wr_clear)
        |=> ($stable(reg_rdata[30:0] & 32'h7FFF_FFF3))); // R5

    AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && !any_strobe) |=> (reg_rdata[1:0] == 2'b00)); // R6

    AST_CLEAR_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && !any_strobe) |=> $stable(reg_rdata[30:4])); // R8

    AST_CAPTURE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && any_strobe) |=> (reg_rdata[1:0] != 2'b00)); // R7

    AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req == (reg_rdata[0] && reg_rdata[2])); // R10

    AST_SERR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        serr_req == (reg_rdata[1] && reg_rdata[3])); // R10

    AST_SCRUB_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_en == !reg_rdata[31]); // R11
endmodule

bind ecc_err_capture ecc_err_capture_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sbe_strobe (sbe_strobe),
    .mbe_strobe (mbe_strobe),
    .reg_wr_en  (reg_wr_en),
    .reg_be     (reg_be),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .nmi_req    (nmi_req),
    .serr_req   (serr_req),
    .scrub_en   (scrub_en)
);

// File: tb/ecc_err_capture_tb_top.sv
// Bench for ecc_err_capture: directed cases plus a random phase. A
// behavioural reference model is compared on every falling edge.
module ecc_err_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sbe_strobe = 1'b0, mbe_strobe = 1'b0;
    logic [31:0] err_addr = '0;
    logic [7:0]  err_syndrome = '0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        nmi_req, serr_req, scrub_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state
    bit        m_sbe, m_mbe, m_nmi_en, m_serr_en, m_scrub_dis;
    bit [18:0] m_addr;
    bit [7:0]  m_syn;

    always #10 clk = ~clk; // 50 MHz

    ecc_err_capture dut_i (
        .clk (clk), .rst_n (rst_n),
        .sbe_strobe (sbe_strobe), .mbe_strobe (mbe_strobe),
        .err_addr (err_addr), .err_syndrome (err_syndrome),
        .reg_wr_en (reg_wr_en), .reg_be (reg_be), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .nmi_req (nmi_req),
        .serr_req (serr_req), .scrub_en (scrub_en)
    );

    function automatic bit [31:0] model_word();
        return {m_scrub_dis, m_addr, m_syn, m_serr_en, m_nmi_en, m_mbe, m_sbe};
    endfunction

    // Reference model: updated behaviourally on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sbe = 0; m_mbe = 0; m_nmi_en = 0; m_serr_en = 0; m_scrub_dis = 0;
            m_addr = 0; m_syn = 0;
        end else begin
            bit clr, held;
            clr  = reg_wr_en && reg_be[0] && (reg_wdata[0] || reg_wdata[1]);
            held = (m_sbe || m_mbe) && !clr;
            if (clr) begin m_sbe = 0; m_mbe = 0; end
            if (!held && (sbe_strobe || mbe_strobe)) begin
                if (mbe_strobe) m_mbe = 1; else m_sbe = 1;
                m_addr = err_addr[31:13];
                m_syn  = err_syndrome;
            end
            if (reg_wr_en && reg_be[0]) begin
                m_nmi_en  = reg_wdata[2];
                m_serr_en = reg_wdata[3];
            end
            if (reg_wr_en && reg_be[3]) m_scrub_dis = reg_wdata[31];
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk("model rdata", reg_rdata, model_word());
            chk("model R10 nmi", {31'b0, nmi_req}, {31'b0, m_sbe && m_nmi_en});
            chk("model R10 serr", {31'b0, serr_req}, {31'b0, m_mbe && m_serr_en});
            chk("model R11 scrub", {31'b0, scrub_en}, {31'b0, !m_scrub_dis});
        end
    end

    // One cycle of stimulus, driven at the falling edge and then released.
    task automatic cyc(bit s, bit m, logic [31:0] a, logic [7:0] syn,
                       bit we, logic [3:0] be, logic [31:0] wd);
        sbe_strobe = s; mbe_strobe = m; err_addr = a; err_syndrome = syn;
        reg_wr_en = we; reg_be = be; reg_wdata = wd;
        @(negedge clk);
        sbe_strobe = 0; mbe_strobe = 0; reg_wr_en = 0; reg_be = 0; reg_wdata = 0;
    endtask

    function automatic logic [31:0] fld(logic [31:0] a, logic [7:0] s);
        return {1'b0, a[31:13], s, 4'b0};
    endfunction

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] keep;
        repeat (3) @(negedge clk);
        chk("R1 reset rdata", reg_rdata, 32'h0);
        chk("R1 reset outs", {29'b0, nmi_req, serr_req, scrub_en}, 32'h1);
        rst_n = 1;
        @(negedge clk);

        // R2: single-bit capture
        cyc(1, 0, 32'hDEAD_B123, 8'h5A, 0, 0, 0);
        chk("R2 sbe capture", reg_rdata, fld(32'hDEAD_B123, 8'h5A) | 32'h1);
        // R5: a later error is ignored
        cyc(0, 1, 32'h1234_5678, 8'hC3, 0, 0, 0);
        chk("R5 first held", reg_rdata, fld(32'hDEAD_B123, 8'h5A) | 32'h1);
        // R9 / R10: enable NMI without clearing
        cyc(0, 0, 0, 0, 1, 4'b0001, 32'h4);
        chk("R10 nmi level", {31'b0, nmi_req}, 32'h1);
        chk("R9 nmi_en bit", reg_rdata, fld(32'hDEAD_B123, 8'h5A) | 32'h5);
        // R6 / R8: clear via bit 0; fields stay
        cyc(0, 0, 0, 0, 1, 4'b0001, 32'h5);
        chk("R8 fields after clear", reg_rdata, fld(32'hDEAD_B123, 8'h5A) | 32'h4);
        chk("R10 nmi drops", {31'b0, nmi_req}, 32'h0);
        // R3: multi-bit capture
        cyc(0, 1, 32'h8000_2000, 8'hF0, 0, 0, 0);
        chk("R3 mbe capture", reg_rdata, fld(32'h8000_2000, 8'hF0) | 32'h6);
        // R6: writing 0 to flags has no effect, enables serr
        cyc(0, 0, 0, 0, 1, 4'b0001, 32'h8);
        chk("R6 write zero keeps", reg_rdata, fld(32'h8000_2000, 8'hF0) | 32'hA);
        chk("R10 serr level", {31'b0, serr_req}, 32'h1);
        // R6: byte lane 0 disabled means no clear; R9 lanes 1,2 read-only
        cyc(0, 0, 0, 0, 1, 4'b0110, 32'hFFFF_FFFF);
        chk("R6 no lane no clear", reg_rdata, fld(32'h8000_2000, 8'hF0) | 32'hA);
        // R6: clear via bit 1 alone clears the multi-bit flag
        cyc(0, 0, 0, 0, 1, 4'b0001, 32'hA);
        chk("R6 clear via mbe bit", reg_rdata[1:0], 32'h0);
        // R4: both strobes together
        cyc(1, 1, 32'h4444_E000, 8'h11, 0, 0, 0);
        chk("R4 mbe priority", reg_rdata, fld(32'h4444_E000, 8'h11) | 32'hA);
        // R7: strobe in the clearing cycle is captured
        cyc(1, 0, 32'h0F0F_0000, 8'h99, 1, 4'b0001, 32'h3);
        chk("R7 capture on clear", reg_rdata, fld(32'h0F0F_0000, 8'h99) | 32'h1);
        // R11: scrub disable through lane 3
        cyc(0, 0, 0, 0, 1, 4'b1000, 32'h8000_0000);
        chk("R11 scrub off", {31'b0, scrub_en}, 32'h0);
        chk("R9 bit31 set", {31'b0, reg_rdata[31]}, 32'h1);
        keep = reg_rdata;
        cyc(0, 0, 0, 0, 1, 4'b0110, 32'h0000_0000);
        chk("R9 lanes 1-2 ignored", reg_rdata, keep);

        // Random phase: the model compare covers every cycle.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] & r[1], r[2] & r[3] & r[4], $urandom, 8'($urandom),
                r[5] & r[6], r[11:8], $urandom);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule